// File: doc/BRIEF.md
# Serial Sampling Converter Frame and Power-Mode Controller

This block is the digital control side of a small serial sampling converter. It runs on a fast system clock. The serial clock and the active-low chip select arrive as ordinary synchronous inputs, and the block finds their edges by comparing each one with its value on the previous cycle. A falling chip select starts a frame. At that moment the block latches the conversion code from a parallel port, which stands in for the analog approximation core, and it starts driving the data pin.

Each counted falling edge of the serial clock moves the data pin on by one position of a sixteen-position word. The block keeps the hold/track indicator, and it floats the data pin again once the word ends or once the chip select rises, whichever comes first.

The same edge counts drive a power-mode machine. After reset the mode is unknown. Chip select rising after a mid-range number of falling edges puts the block into shutdown. Holding chip select low through the tenth falling edge brings the block back to normal. A status flag marks whether the word in the current frame is a real result. That flag is low for the first frame after reset and for the first frame after waking from shutdown.

Top module: `sconv_ctrl`

## Requirements
- R1: After synchronous reset, `sdata_oe_o`=0, `sdata_o`=0, `track_o`=1, `mode_o`=2'b00 (unknown) and `result_valid_o`=0.
- R2: The cycle after a chip-select fall, `sdata_oe_o`=1 and `sdata_o`=0. The code on `conv_code_i` in that cycle is the one shifted out, and later changes of `conv_code_i` during the frame have no effect on the word.
- R3: After the k-th counted serial-clock falling edge (k from 1 to 15), `sdata_o` carries word position k. Positions 0 to 2 are zero, positions 3 to 10 carry the code most significant bit first (position p holds code bit 10-p), and positions 11 to 15 are zero.
- R4: From the 16th falling edge on, `sdata_oe_o`=0 and `sdata_o`=0. Further serial-clock edges in the same frame neither re-enable the pin nor change the mode, because the falling-edge count saturates at 16.
- R5: A chip-select rise at any point floats the data pin (`sdata_oe_o`=0) from the next cycle on.
- R6: `track_o` goes to 0 on a chip-select fall. It returns to 1 on the 13th counted rising serial-clock edge of the frame, or on a chip-select rise if that comes first.
- R7: A chip-select rise after 2 to 9 falling edges aborts the frame and sets `mode_o`=2'b10 (shutdown) with `result_valid_o`=0.
- R8: A chip-select rise after 0 or 1 falling edges leaves `mode_o` unchanged, including the unknown mode after reset.
- R9: The 10th falling edge of a frame sets `mode_o`=2'b01 (normal). A chip-select rise after 10 or more falling edges keeps the normal mode, even when the word is cut short.
- R10: On each chip-select fall, `result_valid_o` becomes 1 when the mode is normal at that moment and 0 otherwise. This makes the first frame after reset or after shutdown a dummy.
- R11: While chip select stays high, serial-clock activity changes neither the mode nor the data pin. Shutdown lasts until chip select falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, synchronous to clk |
| cs_n_i | input | 1 | Active-low chip select, synchronous to clk |
| conv_code_i | input | DATA_W | Conversion code from the approximation core |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Data pin drive enable (0 = high impedance) |
| track_o | output | 1 | 1 = tracking, 0 = holding the sample |
| mode_o | output | 2 | Power mode: 00 unknown, 01 normal, 10 shutdown |
| result_valid_o | output | 1 | The word of the current frame is a real result |

## Verification
The assertions take for granted that `sclk_i` and `cs_n_i` never change in the same system-clock cycle. They also take for granted that the serial clock idles high when chip select falls, so that the first serial-clock edge of a frame is a falling one. The bench changes only one of these two inputs per step, on the inactive clock edge, and always returns the serial clock high before it moves chip select. Under these conditions each edge counter sees a clean, strictly alternating sequence of events, and the saturation and mode checks hold.

// File: rtl/sconv_pkg.sv
package sconv_pkg;
  typedef enum logic [1:0] {
    MODE_UNKNOWN  = 2'b00,
    MODE_NORMAL   = 2'b01,
    MODE_SHUTDOWN = 2'b10
  } pmode_e;
endpackage

// File: rtl/sconv_edge.sv
module sconv_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= RST_VAL;
    else     lvl_q <= sig_i;
  end

  assign rise_o = ~lvl_q & sig_i;
  assign fall_o = lvl_q & ~sig_i;
endmodule

// File: rtl/sconv_count.sv
module sconv_count #(
  parameter int MAX = 16,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr)                    cnt_o <= '0;
    else if (inc && cnt_o != W'(MAX))  cnt_o <= cnt_o + 1'b1;
  end

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= W'(MAX));
endmodule

// File: rtl/sconv_shift.sv
module sconv_shift #(
  parameter int DATA_W     = 8,
  parameter int LEAD_ZEROS = 3,
  parameter int FRAME_LEN  = 16,
  parameter int CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              step_i,
  input  logic [CNT_W-1:0]  fall_cnt_i,
  input  logic [DATA_W-1:0] code_i,
  output logic              sdata_o,
  output logic              sdata_oe_o
);
  localparam int TRAIL = FRAME_LEN - LEAD_ZEROS - DATA_W;

  logic [FRAME_LEN-1:0] word_c;
  logic [FRAME_LEN-1:0] shreg_q;
  logic                 last_c;

  assign word_c = {{LEAD_ZEROS{1'b0}}, code_i, {TRAIL{1'b0}}};
  assign last_c = (fall_cnt_i == CNT_W'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q    <= '0;
      sdata_o    <= 1'b0;
      sdata_oe_o <= 1'b0;
    end else if (start_i) begin
      shreg_q    <= word_c;
      sdata_o    <= word_c[FRAME_LEN-1];
      sdata_oe_o <= 1'b1;
    end else if (abort_i) begin
      sdata_o    <= 1'b0;
      sdata_oe_o <= 1'b0;
    end else if (step_i) begin
      if (last_c) begin
        sdata_o    <= 1'b0;
        sdata_oe_o <= 1'b0;
      end else begin
        shreg_q <= shreg_q << 1;
        sdata_o <= shreg_q[FRAME_LEN-2];
      end
    end
  end

  // R4
  float_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !sdata_oe_o |-> !sdata_o);

  // R4
  end_float_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_cnt_i == CNT_W'(FRAME_LEN)) |-> !sdata_oe_o);

  // R2
  lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdata_oe_o) |-> !sdata_o);
endmodule

// File: rtl/sconv_power.sv
module sconv_power
  import sconv_pkg::*;
#(
  parameter int SLEEP_MIN = 2,
  parameter int AWAKE_AT  = 10,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             fall_inc_i,
  input  logic [CNT_W-1:0] fall_cnt_i,
  output pmode_e           mode_o,
  output logic             valid_o
);
  logic sleep_c;
  logic wake_c;

  assign sleep_c = cs_rise_i && (fall_cnt_i >= CNT_W'(SLEEP_MIN))
                             && (fall_cnt_i <  CNT_W'(AWAKE_AT));
  assign wake_c  = fall_inc_i && (fall_cnt_i == CNT_W'(AWAKE_AT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o  <= MODE_UNKNOWN;
      valid_o <= 1'b0;
    end else begin
      if (sleep_c) begin
        mode_o  <= MODE_SHUTDOWN;
        valid_o <= 1'b0;
      end else if (wake_c) begin
        mode_o <= MODE_NORMAL;
      end
      if (cs_fall_i) valid_o <= (mode_o == MODE_NORMAL);
    end
  end

  // R7
  sleep_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_SHUTDOWN) |-> !valid_o);

  // R8
  no_unknown_return_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o != MODE_UNKNOWN) |=> (mode_o != MODE_UNKNOWN));

  // R10
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> ($past(mode_o) == MODE_NORMAL));
endmodule

// File: rtl/sconv_ctrl.sv
module sconv_ctrl
  import sconv_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LEAD_ZEROS = 3,
  parameter int FRAME_LEN  = 16,
  parameter int TRACK_RISE = 13,
  parameter int SLEEP_MIN  = 2,
  parameter int AWAKE_AT   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic [DATA_W-1:0] conv_code_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              track_o,
  output logic [1:0]        mode_o,
  output logic              result_valid_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic frame_live, fall_inc, rise_inc, step;
  logic [CNT_W-1:0] fall_cnt, rise_cnt;
  pmode_e mode;

  sconv_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst(rst), .sig_i(cs_n_i), .rise_o(cs_rise), .fall_o(cs_fall));

  sconv_edge #(.RST_VAL(1'b1)) u_sclk_edge (
    .clk(clk), .rst(rst), .sig_i(sclk_i), .rise_o(sclk_rise), .fall_o(sclk_fall));

  assign frame_live = ~cs_n_i & ~cs_fall;
  assign fall_inc   = sclk_fall & frame_live;
  assign rise_inc   = sclk_rise & frame_live;
  assign step       = fall_inc && (fall_cnt < CNT_W'(FRAME_LEN));

  sconv_count #(.MAX(FRAME_LEN), .W(CNT_W)) u_fall_cnt (
    .clk(clk), .rst(rst), .clr(cs_n_i), .inc(fall_inc), .cnt_o(fall_cnt));

  sconv_count #(.MAX(TRACK_RISE), .W(CNT_W)) u_rise_cnt (
    .clk(clk), .rst(rst), .clr(cs_n_i), .inc(rise_inc), .cnt_o(rise_cnt));

  sconv_shift #(
    .DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
  ) u_shift (
    .clk(clk), .rst(rst), .start_i(cs_fall), .abort_i(cs_rise), .step_i(step),
    .fall_cnt_i(fall_cnt), .code_i(conv_code_i),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o));

  sconv_power #(
    .SLEEP_MIN(SLEEP_MIN), .AWAKE_AT(AWAKE_AT), .CNT_W(CNT_W)
  ) u_power (
    .clk(clk), .rst(rst), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .fall_inc_i(fall_inc), .fall_cnt_i(fall_cnt),
    .mode_o(mode), .valid_o(result_valid_o));

  assign mode_o = mode;

  always_ff @(posedge clk) begin
    if (rst)                                                   track_o <= 1'b1;
    else if (cs_fall)                                          track_o <= 1'b0;
    else if (cs_rise)                                          track_o <= 1'b1;
    else if (rise_inc && rise_cnt == CNT_W'(TRACK_RISE - 1))   track_o <= 1'b1;
  end

  // R6
  idle_track_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n_i && !cs_rise) |-> track_o);

  // R5
  idle_float_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n_i && !cs_rise) |-> !sdata_oe_o);
endmodule

// File: tb/sconv_ctrl_tb.sv
module sconv_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic [7:0] code = 8'h00;
  logic sdata, sdata_oe, track, valid;
  logic [1:0] mode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int emode = 0;
  bit evalid = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sconv_ctrl u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .conv_code_i(code),
    .sdata_o(sdata), .sdata_oe_o(sdata_oe), .track_o(track),
    .mode_o(mode), .result_valid_o(valid));

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic int exp_bit(input logic [7:0] c, input int k);
    if (k >= 3 && k <= 10) return int'(c[10 - k]);
    return 0;
  endfunction

  task automatic frame(input logic [7:0] c, input int nf);
    string mtag;
    code = c;
    cs_n = 1'b0;
    tick;
    evalid = (emode == 1);
    check("R2 drive on", int'(sdata_oe), 1);
    check("R2 first zero", int'(sdata), 0);
    check("R6 hold", int'(track), 0);
    check("R10 valid at start", int'(valid), int'(evalid));
    code = ~c;
    for (int k = 1; k <= nf; k++) begin
      sclk = 1'b0;
      tick;
      if (k == 10) emode = 1;
      if (k < 16) begin
        check("R3 drive", int'(sdata_oe), 1);
        check("R3 bit", int'(sdata), exp_bit(c, k));
      end else begin
        check("R4 float", int'(sdata_oe), 0);
        check("R4 zero", int'(sdata), 0);
      end
      check("R9 mode in frame", int'(mode), emode);
      sclk = 1'b1;
      tick;
      check("R6 track", int'(track), (k >= 13) ? 1 : 0);
    end
    cs_n = 1'b1;
    tick;
    if (nf >= 2 && nf < 10) begin
      emode = 2;
      evalid = 1'b0;
    end
    mtag = (nf < 2) ? "R8 mode kept" : (nf < 10) ? "R7 shutdown" : "R9 normal";
    check("R5 float on rise", int'(sdata_oe), 0);
    check("R6 track on rise", int'(track), 1);
    check(mtag, int'(mode), emode);
    check("R10 valid after", int'(valid), int'(evalid));
    tick;
  endtask

  initial begin
    repeat (3) tick;
    rst = 1'b0;
    tick;
    // R1 reset state
    check("R1 oe", int'(sdata_oe), 0);
    check("R1 sdata", int'(sdata), 0);
    check("R1 track", int'(track), 1);
    check("R1 mode", int'(mode), 0);
    check("R1 valid", int'(valid), 0);

    frame(8'hA5, 0);
    frame(8'h3C, 1);
    frame(8'h81, 16);
    frame(8'h81, 16);

    for (int nf = 0; nf <= 20; nf++) begin
      frame(8'h5A ^ 8'(nf), nf);
      if (emode != 1) frame(8'hC3, 16);
    end
    for (int nf = 0; nf <= 20; nf++) begin
      frame(8'h0F, 5);
      frame(8'h96 ^ 8'(nf), nf);
      if (emode != 1) frame(8'h69, 16);
    end

    // R11: clock activity with chip select high while asleep
    frame(8'h11, 4);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      tick;
      sclk = 1'b1;
      tick;
      check("R11 mode idle", int'(mode), 2);
      check("R11 float idle", int'(sdata_oe), 0);
    end
    frame(8'h22, 16);
    frame(8'h33, 16);

    for (int c = 0; c < 256; c++) frame(8'(c), 16);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule